// File: doc/BRIEF.md
# Page Table Entry Cache

This block keeps recently fetched 32-bit page-directory and page-table words close to a page walker. The walker sends a word read with a physical byte address and a tag. A lookup that finds the word answers one cycle after acceptance. A lookup that misses sends one read to memory, and the answer comes back when memory returns the word. Memory returns reads in the order they were issued. Answers carry the walker's tag, so a hit may overtake an earlier miss.

The cache is direct-mapped, with one word per line. The line index is taken from the low bits of the word address, masked by a programmable index map. The stored tag is the full word address. Software controls the cache with a configuration word. It invalidates entries with a flush command, which either empties the whole cache or drops the single line that holds a given address. The flush address can be wider than 32 bits. Its top bits come from a separate high-address register, which must be written before the flush command.

Top module: `pte_cache`

## Requirements
- R1: After reset the cache is enabled, the index map is 0x3F and the outstanding-read limit is 8. Eight misses can then be in flight, and `req_ready` falls while all eight are outstanding.
- R2: An accepted miss issues exactly one memory read, with the request's word-aligned address. One cycle after `mem_rsp_valid`, the block answers with the returned data, the request's tag and `rsp_hit` = 0.
- R3: A lookup that matches a valid line answers one cycle after acceptance with the stored word and `rsp_hit` = 1. It issues no memory read.
- R4: A configuration write takes the enable bit from bit 29, the outstanding-read limit from bits [27:24] and the index map from bits [5:0].
- R5: While disabled, every request goes to memory and answers with `rsp_hit` = 0. The words fetched in that state are not kept, so after re-enabling the same address misses once.
- R6: `req_ready` is low while the number of outstanding reads equals the limit. A limit of 0 behaves as a limit of 1.
- R7: A flush command with bit 0 = 0 invalidates every line.
- R8: A flush command with bit 0 = 1 invalidates only the line whose word address is {high register, command[31:2]}. The two low address bits are ignored, because the flush atom is one 4-byte word.
- R9: The high-address register supplies physical bits [33:32] for flushes. It resets to 0 and keeps its value until it is rewritten.
- R10: A flush that hits the address of an outstanding fill stops that fill from being stored. The requester still receives the returned data.
- R11: The line index is word-address bits [4:0] ANDed with map bits [4:0]. Two addresses that fall on the same index evict each other.
- R12: `req_ready` is low in any cycle where `mem_rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| flush_hi_we | input | 1 | High flush-address register write strobe |
| flush_hi_wdata | input | PA_W-32 | Upper physical address bits for flushes |
| flush_we | input | 1 | Flush command strobe |
| flush_wdata | input | 32 | Flush command: bit 0 type, [31:2] word address |
| req_valid | input | 1 | Walker read request |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_addr | input | PA_W | Physical byte address of the word |
| req_id | input | ID_W | Request tag |
| rsp_valid | output | 1 | Answer valid |
| rsp_id | output | ID_W | Tag of the answered request |
| rsp_data | output | 32 | Returned word |
| rsp_hit | output | 1 | Answer was served from the cache |
| mem_req_valid | output | 1 | Memory read issue |
| mem_req_addr | output | PA_W | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid, in issue order |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
If a valid bit or tag is wrong, the next lookup to that address shows it as a wrong `rsp_hit` value one cycle after acceptance, together with a memory read that is present or missing. If the fill queue keeps a wrong flag, the error only appears on the following lookup of that address. The bench therefore always re-reads after a flush or a disabled fill. If the outstanding count drifts, `req_ready` changes at the wrong point when reads are held back. The bench counts in-flight reads itself and compares `req_ready` against that count.

// File: rtl/pte_cache.sv
module pte_cache #(
  parameter int PA_W    = 34,
  parameter int ID_W    = 4,
  parameter int LINES   = 32,
  parameter int QDEPTH  = 16,
  parameter int LIM_RST = 8,
  parameter logic [5:0] MAP_RST = 6'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              flush_hi_we,
  input  logic [PA_W-33:0]  flush_hi_wdata,
  input  logic              flush_we,
  input  logic [31:0]       flush_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [31:0]       rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int WA_W  = PA_W - 2;
  localparam int IDX_W = $clog2(LINES);
  localparam int QP_W  = $clog2(QDEPTH);
  localparam int CNT_W = QP_W + 1;
  localparam int HI_W  = PA_W - 32;

  logic             en_q;
  logic [3:0]       lim_q;
  logic [5:0]       map_q;
  logic [HI_W-1:0]  hi_q;

  logic [LINES-1:0] vld_q;
  logic [WA_W-1:0]  tag_q [LINES];
  logic [31:0]      dat_q [LINES];

  logic [ID_W-1:0]  qid [QDEPTH];
  logic [WA_W-1:0]  qwa [QDEPTH];
  logic [QDEPTH-1:0] qkeep;
  logic [QP_W-1:0]  wp, rp;
  logic [CNT_W-1:0] cnt_q;

  wire fl_all = flush_we & ~flush_wdata[0];
  wire fl_one = flush_we & flush_wdata[0];
  wire [WA_W-1:0]  fl_wa    = {hi_q, flush_wdata[31:2]};
  wire [WA_W-1:0]  rq_wa    = req_addr[PA_W-1:2];
  wire [IDX_W-1:0] idx_mask = map_q[IDX_W-1:0];
  wire [IDX_W-1:0] rq_idx   = rq_wa[IDX_W-1:0] & idx_mask;
  wire [3:0]       eff_lim  = (lim_q == 4'd0) ? 4'd1 : lim_q;

  assign req_ready = ~mem_rsp_valid & (cnt_q < CNT_W'(eff_lim));

  wire rq_fl = fl_all | (fl_one & (fl_wa == rq_wa));
  wire hit   = en_q & vld_q[rq_idx] & (tag_q[rq_idx] == rq_wa) & ~rq_fl;
  wire acc   = req_valid & req_ready;
  wire miss  = acc & ~hit;

  wire [WA_W-1:0]  hd_wa = qwa[rp];
  wire hd_fl = fl_all | (fl_one & (fl_wa == hd_wa));
  wire fill  = mem_rsp_valid & qkeep[rp] & ~hd_fl;
  wire [IDX_W-1:0] f_idx = hd_wa[IDX_W-1:0] & idx_mask;

  wire unused_bits = ^{cfg_wdata[31:30], cfg_wdata[23:6], flush_wdata[1], req_addr[1:0], map_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      lim_q <= 4'(LIM_RST);
      map_q <= MAP_RST;
      hi_q  <= '0;
    end else begin
      if (cfg_we) begin
        en_q  <= cfg_wdata[29];
        lim_q <= cfg_wdata[27:24];
        map_q <= cfg_wdata[5:0];
      end
      if (flush_hi_we) hi_q <= flush_hi_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++)
        if (fl_all | (fl_one & (tag_q[i] == fl_wa))) vld_q[i] <= 1'b0;
      if (fill) vld_q[f_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[f_idx] <= hd_wa;
      dat_q[f_idx] <= mem_rsp_data;
    end
    if (miss) begin
      qid[wp] <= req_id;
      qwa[wp] <= rq_wa;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
      qkeep <= '0;
    end else begin
      for (int j = 0; j < QDEPTH; j++)
        if (fl_all | (fl_one & (qwa[j] == fl_wa))) qkeep[j] <= 1'b0;
      if (miss) begin
        qkeep[wp] <= en_q & ~rq_fl;
        wp <= wp + 1'b1;
      end
      if (mem_rsp_valid) rp <= rp + 1'b1;
      cnt_q <= cnt_q + CNT_W'(miss) - CNT_W'(mem_rsp_valid);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_id        <= '0;
      rsp_data      <= '0;
      rsp_hit       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      rsp_valid     <= (acc & hit) | mem_rsp_valid;
      rsp_id        <= mem_rsp_valid ? qid[rp] : req_id;
      rsp_data      <= mem_rsp_valid ? mem_rsp_data : dat_q[rq_idx];
      rsp_hit       <= ~mem_rsp_valid;
      mem_req_valid <= miss;
      mem_req_addr  <= {rq_wa, 2'b00};
    end
  end
endmodule

// File: rtl/pte_cache_chk.sv
module pte_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       mem_req_valid,
  input logic       mem_rsp_valid,
  input logic       en_q,
  input logic [3:0] lim_q
);
  logic [4:0] out_c;
  always_ff @(posedge clk) begin
    if (!rst_n) out_c <= '0;
    else out_c <= out_c + 5'(mem_req_valid) - 5'(mem_rsp_valid);
  end
  wire [4:0] lim_eff = (lim_q == 4'd0) ? 5'd1 : {1'b0, lim_q};

  p_fill_blocks_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !req_ready);
  p_fill_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> (rsp_valid && !rsp_hit));
  p_issue_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $past(req_valid && req_ready));
  p_hit_when_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(en_q));
  p_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_c >= lim_eff) |-> !req_ready);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_c <= 5'd15);
endmodule

bind pte_cache pte_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .mem_req_valid(mem_req_valid),
  .mem_rsp_valid(mem_rsp_valid), .en_q(en_q), .lim_q(lim_q)
);

// File: tb/tb_pte_cache.sv
module tb_pte_cache;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst_n = 0;
  logic        cfg_we = 0, flush_hi_we = 0, flush_we = 0;
  logic [31:0] cfg_wdata = 0, flush_wdata = 0;
  logic [1:0]  flush_hi_wdata = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [33:0] req_addr = 0;
  logic [3:0]  req_id = 0;
  logic        rsp_valid, rsp_hit, mem_req_valid;
  logic [3:0]  rsp_id;
  logic [31:0] rsp_data;
  logic [33:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  pte_cache dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flush_hi_we(flush_hi_we), .flush_hi_wdata(flush_hi_wdata),
    .flush_we(flush_we), .flush_wdata(flush_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0, fails = 0;
  logic hold = 0;
  logic [33:0] mq [32];
  int mt = 0, mh = 0;
  logic        got  [16];
  logic [31:0] gdat [16];
  logic        ghit [16];

  function automatic logic [31:0] fdat(input logic [33:0] a);
    return a[33:2] ^ 32'hC3C3_0000;
  endfunction

  always @(posedge clk) begin
    if (mem_req_valid) begin mq[mt % 32] <= mem_req_addr; mt <= mt + 1; end
    if (mem_rsp_valid) mh <= mh + 1;
  end
  always @(negedge clk) begin
    if (!hold && mt != mh) begin
      mem_rsp_valid = 1; mem_rsp_data = fdat(mq[mh % 32]);
    end else mem_rsp_valid = 0;
  end
  always @(negedge clk)
    if (rsp_valid) begin got[rsp_id] = 1; gdat[rsp_id] = rsp_data; ghit[rsp_id] = rsp_hit; end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wcfg(input logic [31:0] w);
    @(negedge clk); #1; cfg_we = 1; cfg_wdata = w;
    @(negedge clk); #1; cfg_we = 0;
  endtask
  task automatic wflush(input logic [31:0] w);
    @(negedge clk); #1; flush_we = 1; flush_wdata = w;
    @(negedge clk); #1; flush_we = 0;
  endtask
  task automatic whi(input logic [1:0] h);
    @(negedge clk); #1; flush_hi_we = 1; flush_hi_wdata = h;
    @(negedge clk); #1; flush_hi_we = 0;
  endtask

  task automatic issue(input logic [33:0] a, input logic [3:0] id);
    got[id] = 0;
    @(negedge clk); #1; req_valid = 1; req_addr = a; req_id = id;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; req_valid = 0;
  endtask

  task automatic waitrsp(input logic [3:0] id);
    for (int k = 0; k < 40 && !got[id]; k++) begin @(negedge clk); #1; end
  endtask

  task automatic access(input logic [33:0] a, input logic [3:0] id, input logic exp_hit, input string tag);
    int m0;
    m0 = mt;
    issue(a, id);
    waitrsp(id);
    repeat (2) @(negedge clk);
    #1;
    chk(got[id] === 1'b1, {tag, " answer"}, 64'(got[id]), 1);
    chk(gdat[id] === fdat(a), {tag, " data"}, 64'(gdat[id]), 64'(fdat(a)));
    chk(ghit[id] === exp_hit, {tag, " hit"}, 64'(ghit[id]), 64'(exp_hit));
    chk((mt - m0) == (exp_hit ? 0 : 1), {tag, " mem reads"}, 64'(mt - m0), exp_hit ? 0 : 1);
  endtask

  localparam logic [34:0] VEC [11] = '{
    {1'b0, 34'h0_0000_1000}, {1'b1, 34'h0_0000_1000},
    {1'b0, 34'h0_0000_1004}, {1'b1, 34'h0_0000_1004},
    {1'b1, 34'h0_0000_1000}, {1'b0, 34'h0_0000_1080},
    {1'b1, 34'h0_0000_1080}, {1'b0, 34'h0_0000_1000},
    {1'b1, 34'h0_0000_1004}, {1'b0, 34'h2_0000_1008},
    {1'b1, 34'h2_0000_1008}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) got[i] = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(req_ready === 1'b1, "R1 reset ready", 64'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R1 reset mem_req_valid", 64'(mem_req_valid), 0);
    rst_n = 1;

    // R2 R3 R11 : table of lookups with collisions at the default map
    for (int v = 0; v < 11; v++)
      access(VEC[v][33:0], 4'(v), VEC[v][34], $sformatf("R2/R3/R11 vec%0d", v));

    // R9 : high bits select the flushed line
    wflush(32'h0000_1009);
    access(34'h2_0000_1008, 1, 1, "R9 hi=0 leaves upper line");
    whi(2'd2);
    wflush(32'h0000_1009);
    access(34'h2_0000_1008, 2, 0, "R9 hi=2 flushes upper line");
    access(34'h2_0000_1008, 3, 1, "R9 refill");
    whi(2'd0);

    // R8 : single-line flush, low bits ignored
    access(34'h0_0000_1000, 4, 1, "R8 pre A");
    wflush(32'h0000_1003);
    access(34'h0_0000_1000, 5, 0, "R8 A flushed");
    access(34'h0_0000_1004, 6, 1, "R8 B kept");

    // R7 : flush all
    wflush(32'h0000_1004);
    wflush(32'h0000_0000);
    access(34'h0_0000_1004, 7, 0, "R7 B after flush all");
    access(34'h0_0000_1000, 8, 0, "R7 A after flush all");

    // R1 R6 R12 : default limit of 8
    hold = 1;
    for (int i = 0; i < 8; i++) issue(34'h0_0000_3000 + 34'(4 * i), 4'(i));
    @(negedge clk); #1;
    chk(req_ready === 1'b0, "R1 ready low at 8 outstanding", 64'(req_ready), 0);
    hold = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (mem_rsp_valid) chk(req_ready === 1'b0, "R12 ready during fill", 64'(req_ready), 0);
    end
    for (int i = 0; i < 8; i++)
      chk(got[i] === 1'b1 && gdat[i] === fdat(34'h0_0000_3000 + 34'(4 * i)) && ghit[i] === 1'b0,
          $sformatf("R1 held miss %0d", i), 64'(gdat[i]), 64'(fdat(34'h0_0000_3000 + 34'(4 * i))));

    // R4 R6 : programmed limits 2 and 0
    wcfg(32'h2200_003F);
    hold = 1;
    issue(34'h0_0000_3100, 1);
    @(negedge clk); #1;
    chk(req_ready === 1'b1, "R6 limit 2 one outstanding", 64'(req_ready), 1);
    issue(34'h0_0000_3104, 2);
    @(negedge clk); #1;
    chk(req_ready === 1'b0, "R4/R6 limit 2 reached", 64'(req_ready), 0);
    hold = 0;
    repeat (10) @(negedge clk);
    wcfg(32'h2000_003F);
    hold = 1;
    issue(34'h0_0000_3108, 3);
    @(negedge clk); #1;
    chk(req_ready === 1'b0, "R6 limit 0 acts as 1", 64'(req_ready), 0);
    hold = 0;
    repeat (10) @(negedge clk);
    wcfg(32'h2800_003F);

    // R5 : disabled bypass, fills not kept
    wcfg(32'h0800_003F);
    access(34'h0_0000_5000, 4, 0, "R5 disabled first");
    access(34'h0_0000_5000, 5, 0, "R5 disabled again");
    wcfg(32'h2800_003F);
    access(34'h0_0000_5000, 6, 0, "R5 enabled not stored");
    access(34'h0_0000_5000, 7, 1, "R5 enabled stored");

    // R10 : flush hits an outstanding fill
    hold = 1;
    issue(34'h0_0000_5104, 9);
    wflush(32'h0000_5105);
    hold = 0;
    waitrsp(9);
    chk(got[9] === 1'b1 && gdat[9] === fdat(34'h0_0000_5104) && ghit[9] === 1'b0,
        "R10 answer still delivered", 64'(gdat[9]), 64'(fdat(34'h0_0000_5104)));
    access(34'h0_0000_5104, 10, 0, "R10 fill dropped");
    access(34'h0_0000_5104, 11, 1, "R10 later fill kept");

    // R11 R4 : index map 0 folds all addresses onto line 0
    wcfg(32'h2800_0000);
    access(34'h0_0000_6000, 12, 0, "R11 G miss");
    access(34'h0_0000_6000, 13, 1, "R11 G hit");
    access(34'h0_0000_6004, 14, 0, "R11 H miss");
    access(34'h0_0000_6000, 15, 0, "R11 G evicted by H");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule